// File: doc/BRIEF.md
# At-Speed Controller Test Sequencer

This block sits next to a finite-state controller that has been made testable. The controller has a multiplexer in front of its state register that picks either its own next-state logic or an on-chip generator of unreachable states. It also has a hold/load control on that register. The sequencer drives the controller's reset, the multiplexer select (`mode_o`), the hold control and the primary-input vector. With these it applies a stored set of combinational test patterns back to back at operating speed.

The pattern program is an elaboration-time table in two parts. The first part walks the controller from reset along normal transitions to each reachable test state. At each such state it applies every input vector that uses that state while the register holds. The second part starts from a fresh reset, loads each unreachable test state through the generator and applies that state's vectors in the same held manner. A compare-enable output marks the cycles in which an external checker samples the controller's outputs. A done flag reports that the run is over.

Top module: `ctl_test_seq`

## Requirements
- R1: While `rst_ni` is low, and in idle after reset until a start pulse is seen, `ctl_rst_o`, `mode_o`, `hold_o`, `cmp_en_o`, `done_o` are 0 and `pi_o` is 0.
- R2: A `start_i` sampled high in idle or done produces, in the next cycle, exactly one cycle with `ctl_rst_o`=1 while `mode_o`, `hold_o`, `cmp_en_o`, `done_o` and `pi_o` are 0.
- R3: Entry k of `TABLE` sits at bits [k*(PI_W+2) +: PI_W+2]. Its top two bits are the opcode (00 end, 01 transition, 10 apply, 11 inject) and its low PI_W bits are the vector. A transition entry gives one cycle with `pi_o`=vector and `mode_o`, `hold_o`, `cmp_en_o` all 0.
- R4: An apply entry gives one cycle with `hold_o`=1, `cmp_en_o`=1, `mode_o`=0 and `pi_o`=vector. Consecutive apply entries follow on consecutive cycles.
- R5: When a transition entry directly follows an apply entry, one extra cycle comes first, with `hold_o`=1, `cmp_en_o`=0, `mode_o`=0 and `pi_o` equal to the transition's vector. The transition cycle follows it.
- R6: The first end entry gives one cycle with `ctl_rst_o`=1 and the other controls 0, and opens the second phase. The second end entry gives one cycle with all outputs 0, after which `done_o` rises.
- R7: An inject entry gives one cycle with `mode_o`=1, `hold_o`=0, `cmp_en_o`=0 and `pi_o`=vector.
- R8: `cmp_en_o` is 1 in exactly the apply cycles and in no other cycle.
- R9: Once `done_o` is 1 it stays 1, with all other outputs 0, until `start_i` is sampled high.
- R10: A `start_i` pulse while a run is in progress has no effect on the output sequence.
- R11: Reading past the last table index behaves as an end entry.
- R12: Pulling `rst_ni` low during a run forces all outputs to 0 at once, and the next start replays the whole program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when idle or done |
| ctl_rst_o | output | 1 | Reset to the controller under test |
| mode_o | output | 1 | 1 selects the unreachable-state generator into the state register |
| hold_o | output | 1 | 1 holds the controller state register |
| pi_o | output | PI_W | Primary-input vector to the controller |
| cmp_en_o | output | 1 | Output comparison strobe |
| done_o | output | 1 | Run complete |

## Verification
All outputs are decoded from registered state without a further register. The opening reset cycle therefore appears in the cycle right after the edge that samples `start_i`. Each later program cycle appears one edge after the previous one, and `done_o` rises one edge after the closing all-zero cycle. The bench builds the expected per-cycle output stream from its own table using the rules above. It compares that stream, and the compare strobe, on every falling edge starting with the cycle after the start edge. It also checks the immediate effect of an asynchronous reset a few time units after `rst_ni` falls.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  typedef enum logic [1:0] {
    OP_END    = 2'b00,
    OP_TRANS  = 2'b01,
    OP_APPLY  = 2'b10,
    OP_INJECT = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    CY_PARK, CY_RST, CY_TRANS, CY_HOLD, CY_APPLY, CY_INJECT
  } cyc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RSTV, ST_RUNV, ST_RUNI, ST_DONE
  } st_e;
endpackage

// File: rtl/tseq_table.sv
module tseq_table
  import tseq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PI_W  = 4,
  parameter int EW    = PI_W + 2,
  parameter int PTR_W = $clog2(DEPTH + 1),
  parameter logic [DEPTH*EW-1:0] TABLE = '0
) (
  input  logic [PTR_W-1:0] ptr_i,
  output op_e              op_o,
  output logic [PI_W-1:0]  vec_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH);

  logic [EW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign ent[g] = TABLE[g*EW +: EW];
  end

  logic [IDX_W-1:0] idx;
  assign idx = IDX_W'(ptr_i);

  always_comb begin
    op_o  = OP_END;
    vec_o = '0;
    if (ptr_i < PTR_END) begin  // past the end reads as end
      op_o  = op_e'(ent[idx][EW-1 -: 2]);
      vec_o = ent[idx][PI_W-1:0];
    end
  end
endmodule

// File: rtl/tseq_engine.sv
module tseq_engine
  import tseq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  op_e              op_i,
  output logic [PTR_W-1:0] ptr_o,
  output cyc_e             cyc_o,
  output logic             done_o
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH);

  st_e              st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic             last_q, last_d;  // previous cycle applied a pattern

  assign ptr_inc = (ptr_q == PTR_END) ? ptr_q : ptr_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    last_d = last_q;
    cyc_o  = CY_PARK;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_d   = ST_RSTV;
          ptr_d  = '0;
          last_d = 1'b0;
        end
      end
      ST_RSTV: begin
        cyc_o = CY_RST;
        st_d  = ST_RUNV;
      end
      ST_RUNV, ST_RUNI: begin
        unique case (op_i)
          OP_END: begin
            last_d = 1'b0;
            if (st_q == ST_RUNV) begin
              cyc_o = CY_RST;  // phase boundary is the second-phase reset
              st_d  = ST_RUNI;
              ptr_d = ptr_inc;
            end else begin
              st_d = ST_DONE;
            end
          end
          OP_TRANS: begin
            if (last_q) begin
              cyc_o  = CY_HOLD;  // keep tested state one more cycle
              last_d = 1'b0;
            end else begin
              cyc_o = CY_TRANS;
              ptr_d = ptr_inc;
            end
          end
          OP_APPLY: begin
            cyc_o  = CY_APPLY;
            ptr_d  = ptr_inc;
            last_d = 1'b1;
          end
          OP_INJECT: begin
            cyc_o  = CY_INJECT;
            ptr_d  = ptr_inc;
            last_d = 1'b0;
          end
          default: ;
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      last_q <= last_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign done_o = (st_q == ST_DONE);

  p_ptr_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_END);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((st_q == ST_RUNV) || (st_q == ST_RUNI)) && start_i) |=> (st_q != ST_RSTV));

  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/tseq_drive.sv
module tseq_drive
  import tseq_pkg::*;
#(
  parameter int PI_W = 4
) (
  input  cyc_e            cyc_i,
  input  logic [PI_W-1:0] vec_i,
  output logic            ctl_rst_o,
  output logic            mode_o,
  output logic            hold_o,
  output logic            cmp_en_o,
  output logic [PI_W-1:0] pi_o,
  output logic            load_o
);
  always_comb begin
    ctl_rst_o = 1'b0;
    mode_o    = 1'b0;
    hold_o    = 1'b0;
    cmp_en_o  = 1'b0;
    pi_o      = '0;
    unique case (cyc_i)
      CY_RST:    ctl_rst_o = 1'b1;
      CY_TRANS:  pi_o = vec_i;
      CY_HOLD: begin
        hold_o = 1'b1;
        pi_o   = vec_i;
      end
      CY_APPLY: begin
        hold_o   = 1'b1;
        cmp_en_o = 1'b1;
        pi_o     = vec_i;
      end
      CY_INJECT: begin
        mode_o = 1'b1;
        pi_o   = vec_i;
      end
      default: ;
    endcase
  end

  assign load_o = (cyc_i == CY_TRANS);
endmodule

// File: rtl/ctl_test_seq.sv
module ctl_test_seq
  import tseq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PI_W  = 4,
  parameter logic [DEPTH*(PI_W+2)-1:0] TABLE = {
    6'b10_1001, 6'b11_0000, 6'b00_0000, 6'b10_0110,
    6'b01_0101, 6'b10_0010, 6'b10_0001, 6'b01_0011
  }
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            ctl_rst_o,
  output logic            mode_o,
  output logic            hold_o,
  output logic [PI_W-1:0] pi_o,
  output logic            cmp_en_o,
  output logic            done_o
);
  localparam int EW    = PI_W + 2;
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] ptr;
  op_e              op;
  logic [PI_W-1:0]  vec;
  cyc_e             cyc;
  logic             load;

  tseq_table #(
    .DEPTH(DEPTH), .PI_W(PI_W), .EW(EW), .PTR_W(PTR_W), .TABLE(TABLE)
  ) u_table (
    .ptr_i(ptr), .op_o(op), .vec_o(vec)
  );

  tseq_engine #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op),
    .ptr_o(ptr), .cyc_o(cyc), .done_o(done_o)
  );

  tseq_drive #(.PI_W(PI_W)) u_drive (
    .cyc_i(cyc), .vec_i(vec), .ctl_rst_o(ctl_rst_o), .mode_o(mode_o),
    .hold_o(hold_o), .cmp_en_o(cmp_en_o), .pi_o(pi_o), .load_o(load)
  );

  p_hold_before_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_o |=> !load);

  p_rst_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rst_o |=> !ctl_rst_o);

  p_done_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (ctl_rst_o && !done_o));

  p_done_parked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(hold_o || mode_o || cmp_en_o || ctl_rst_o));
endmodule

// File: tb/ctl_test_seq_bench.sv
`timescale 1ns/1ps
module ctl_test_seq_bench;
  localparam int BD  = 16;
  localparam int BP  = 5;
  localparam int BEW = BP + 2;
  localparam int OW  = BP + 5;

  // R3 encoding: opcode in top two bits, vector below; pseudo-random vectors
  function automatic logic [BD*BEW-1:0] mk_table();
    logic [BD*BEW-1:0] t;
    bit [31:0] s;
    logic [1:0] op;
    t = '0;
    s = 32'd2463;
    for (int k = 0; k < BD; k++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      case (k)
        8:          op = 2'b00;
        9, 12, 14:  op = 2'b11;
        0, 3, 4, 6: op = 2'b01;
        default:    op = 2'b10;
      endcase
      t[k*BEW +: BEW] = {op, s[20:16]};
    end
    return t;
  endfunction

  localparam logic [BD*BEW-1:0] BTAB = mk_table();

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic ctl_rst_o, mode_o, hold_o, cmp_en_o, done_o;
  logic [BP-1:0] pi_o;

  always #2.5 clk = ~clk;

  ctl_test_seq #(.DEPTH(BD), .PI_W(BP), .TABLE(BTAB)) u_ctl_test_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .ctl_rst_o(ctl_rst_o),
    .mode_o(mode_o), .hold_o(hold_o), .pi_o(pi_o), .cmp_en_o(cmp_en_o),
    .done_o(done_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [OW-1:0] exp_v [64];
  int            exp_tag [64];
  int            n_exp = 0;

  function automatic logic [1:0] t_op(int k);
    return (k < BD) ? BTAB[k*BEW+BP +: 2] : 2'b00;  // R11 past end reads as end
  endfunction

  function automatic logic [BP-1:0] t_vec(int k);
    return (k < BD) ? BTAB[k*BEW +: BP] : '0;
  endfunction

  // packing: {rst, mode, hold, cmp, done, pi}
  function automatic void push(logic r, logic m, logic h, logic c, logic [BP-1:0] v, int tag);
    exp_v[n_exp]   = {r, m, h, c, 1'b0, v};
    exp_tag[n_exp] = tag;
    n_exp++;
  endfunction

  function automatic void build_stream();
    int ptr = 0;
    bit phase2 = 1'b0;
    bit last_ap = 1'b0;
    bit fin = 1'b0;
    n_exp = 0;
    push(1, 0, 0, 0, '0, 2);                 // R2 opening reset
    while (!fin) begin
      case (t_op(ptr))
        2'b00: begin
          last_ap = 1'b0;
          if (!phase2) begin
            push(1, 0, 0, 0, '0, 6);         // R6 second-phase reset
            phase2 = 1'b1;
            ptr++;
          end else begin
            push(0, 0, 0, 0, '0, (ptr >= BD) ? 11 : 6);  // R11 / R6 closing cycle
            fin = 1'b1;
          end
        end
        2'b01: begin
          if (last_ap) push(0, 0, 1, 0, t_vec(ptr), 5);  // R5 extra hold
          last_ap = 1'b0;
          push(0, 0, 0, 0, t_vec(ptr), 3);   // R3 transition
          ptr++;
        end
        2'b10: begin
          push(0, 0, 1, 1, t_vec(ptr), 4);   // R4 apply
          last_ap = 1'b1;
          ptr++;
        end
        default: begin
          push(0, 1, 0, 0, t_vec(ptr), 7);   // R7 inject
          last_ap = 1'b0;
          ptr++;
        end
      endcase
    end
  endfunction

  function automatic logic [OW-1:0] act();
    return {ctl_rst_o, mode_o, hold_o, cmp_en_o, done_o, pi_o};
  endfunction

  task automatic chk(logic [OW-1:0] got, logic [OW-1:0] want, int tag);
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h at %0t", tag, got, want, $time);
    end
  endtask

  task automatic run_seq(bit noise);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < n_exp; i++) begin
      if (i > 0) @(negedge clk);
      chk(act(), exp_v[i], exp_tag[i]);
      // R8 strobe only on apply cycles
      chk(OW'(cmp_en_o), OW'(exp_tag[i] == 4), 8);
      if (noise) start_i = (($urandom % 3) == 0);  // R10 ignored while running
    end
    start_i = 1'b0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(act(), {5'b00001, {BP{1'b0}}}, 9);  // R9 parked and done
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL R6: watchdog, done_o=%0b expected 1", done_o);
    summary();
  end

  initial begin
    void'($urandom(32'd97));
    build_stream();
    repeat (3) @(negedge clk);
    chk(act(), '0, 1);                         // R1 in reset
    rst_ni = 1'b1;
    repeat (2 + ($urandom % 5)) @(negedge clk);
    chk(act(), '0, 1);                         // R1 idle
    run_seq(1'b0);
    repeat ($urandom % 4) @(negedge clk);
    run_seq(1'b1);
    // R12 asynchronous reset mid-run
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4 + ($urandom % 6)) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(act(), '0, 12);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(act(), '0, 12);
    run_seq(1'b0);                             // R12 full replay
    summary();
  end
endmodule